// File: doc/BRIEF.md
# Receive Scatter-Gather Descriptor Writer

This block is the receive half of a scatter-gather DMA channel. Packets come in as a byte stream with valid/ready handshake and an end-of-packet marker. A separate sideband stream delivers a fixed group of five 32-bit words that go with the next packet. The engine walks a linked chain of descriptors in memory, starting at a current pointer. Each descriptor names a buffer and a byte capacity. The engine fills each buffer with packet bytes and writes a status word back into the descriptor. It then follows the link to the next descriptor, and stops as idle once it has finished the descriptor that sits at the tail pointer.

A descriptor occupies nine 32-bit words at byte offsets 0 (link to next descriptor), 4 (buffer byte address), 8 (control, capacity in bits 22:0), 12 (status) and 16 to 32 (five sideband words). A packet larger than one buffer spills into the following descriptors. Software, or a register block around this engine, drives the run level and writes the current and tail pointers. A one-cycle completion pulse per finished descriptor feeds the interrupt coalescing logic, which lives elsewhere.

Top module: `sg_rx_writer`

## Requirements
- R1: A sideband group ending (sb_last) on exactly its fifth word is latched as the five words for the next packet. A group of any other length pulses sb_error one cycle after its last word and leaves the latched words unchanged.
- R2: rx_ready is high only while run_en is high, the channel is neither idle nor halted, and a fetched descriptor still has room. Dropping run_en drops rx_ready at once.
- R3: If the status word (offset 12) of a fetched descriptor already has bit 31 set, halted rises, no data is accepted and cur_ptr is left unchanged.
- R4: A descriptor receives at most the byte count in bits 22:0 of its control word. Its bytes land at consecutive byte addresses from its buffer address, and the rest of the packet continues in the next descriptor.
- R5: Every used descriptor gets a status write with bit 31 set and its received byte count in bits 22:0.
- R6: Status bit 27 marks the first descriptor of a packet, and bit 26 marks the descriptor holding the packet's last byte. Neither bit is set on any other descriptor.
- R7: The descriptor holding the last byte gets the five latched sideband words at offsets 16, 20, 24, 28 and 32, in arrival order.
- R8: After each descriptor, cur_ptr takes the link from offset 0. If the finished descriptor's address equals the tail pointer, idle rises.
- R9: If idle rises in the middle of a packet, the remaining bytes are held off with rx_ready low. A tail pointer write clears idle, and the packet resumes without a new start mark.
- R10: desc_done pulses for exactly one cycle per descriptor written back.
- R11: After reset, halted is 1, idle is 0 and rx_ready is 0, and no memory access is made. A rising edge of run_en clears halted and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run level; a rising edge restarts the channel |
| cur_wr | input | 1 | Load strobe for the current descriptor pointer |
| cur_wdata | input | AW | Value for the current pointer |
| tail_wr | input | 1 | Load strobe for the tail pointer; clears idle |
| tail_wdata | input | AW | Value for the tail pointer |
| cur_ptr | output | AW | Current descriptor byte address |
| halted | output | 1 | Channel halted |
| idle | output | 1 | Tail descriptor finished |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_last | input | 1 | Last byte of the packet |
| rx_ready | output | 1 | Engine accepts a data byte |
| sb_valid | input | 1 | Sideband word valid |
| sb_data | input | 32 | Sideband word |
| sb_last | input | 1 | Last word of a sideband group |
| sb_error | output | 1 | Sideband group had the wrong length |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| desc_done | output | 1 | One-cycle pulse per written-back descriptor |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 23-bit length field and five sideband words, over a 1 KiB memory model with eight descriptors on a 64-byte stride. Capacities of 1 to 8 bytes let packets of 1 to 12 bytes cover several cases: a packet that fills exactly one buffer, one that leaves room, and one that spills across three descriptors with a short final one. The short sideband width keeps the wrong-length groups (four and six words) cheap to provoke. The same small ring is used to stop at the tail in mid-packet and to present a descriptor that is already marked complete.

// File: rtl/sg_rx_pkg.sv
package sg_rx_pkg;

  typedef enum logic [3:0] {
    E_WAIT,
    E_RD_NXT,
    E_RD_BUF,
    E_RD_CTL,
    E_RD_STS,
    E_CHK,
    E_DATA,
    E_WB_STS,
    E_WB_APP,
    E_ADV
  } eng_state_t;

  // descriptor byte offsets
  localparam int OFF_NEXT = 0;
  localparam int OFF_BUF  = 4;
  localparam int OFF_CTL  = 8;
  localparam int OFF_STS  = 12;
  localparam int OFF_APP  = 16;

  // status bit positions
  localparam int STS_DONE_BIT = 31;
  localparam int STS_SOF_BIT  = 27;
  localparam int STS_EOF_BIT  = 26;

endpackage

// File: rtl/sg_rx_sideband.sv
module sg_rx_sideband #(
  parameter int WORDS = 5,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sb_valid,
  input  logic [DW-1:0]       sb_data,
  input  logic                sb_last,
  output logic [WORDS*DW-1:0] app_flat,
  output logic                sb_error
);
  localparam int IW = $clog2(WORDS + 1);
  localparam int SW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [DW-1:0] stage [WORDS];
  logic [IW-1:0] idx;
  logic          good_end;

  assign good_end = sb_valid && sb_last && (idx == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      sb_error <= 1'b0;
    end else begin
      sb_error <= 1'b0;
      if (sb_valid) begin
        if (idx < IW'(WORDS)) stage[idx[SW-1:0]] <= sb_data;
        if (sb_last) begin
          idx <= '0;
          if (idx != IW'(WORDS - 1)) sb_error <= 1'b1;
        end else if (idx != IW'(WORDS)) begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_app
    always_ff @(posedge clk) begin
      if (rst) begin
        app_flat[g*DW +: DW] <= '0;
      end else if (good_end) begin
        if (g == WORDS - 1) app_flat[g*DW +: DW] <= sb_data;
        else                app_flat[g*DW +: DW] <= stage[g];
      end
    end
  end

  AST_ERR_KEEPS_SIDEBAND: assert property (@(posedge clk) disable iff (rst)
    sb_error |-> $stable(app_flat)); // R1
  AST_SB_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(WORDS)); // R1

endmodule

// File: rtl/sg_rx_chan_regs.sv
module sg_rx_chan_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_wdata,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_wdata,
  input  logic          adv,
  input  logic [AW-1:0] adv_next,
  input  logic          halt_set,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle
);
  logic          run_q;
  logic [AW-1:0] tail_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      halted   <= 1'b1;
      idle     <= 1'b0;
      cur_ptr  <= '0;
      tail_ptr <= '0;
    end else begin
      run_q <= run_en;
      if (run_en && !run_q) begin
        halted <= 1'b0;
        idle   <= 1'b0;
      end
      if (cur_wr) cur_ptr <= cur_wdata;
      if (tail_wr) begin
        tail_ptr <= tail_wdata;
        idle     <= 1'b0;
      end
      if (adv) begin
        cur_ptr <= adv_next;
        if (cur_ptr == tail_ptr && !tail_wr) idle <= 1'b1;
      end
      if (halt_set) halted <= 1'b1;
    end
  end

  AST_IDLE_FROM_ADV: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(adv)); // R8
  AST_HALT_FROM_ENGINE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(halt_set)); // R3

endmodule

// File: rtl/sg_rx_engine.sv
module sg_rx_engine
  import sg_rx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 23,
  parameter int WORDS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             idle,
  input  logic             halted,
  input  logic [AW-1:0]    cur_ptr,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_ready,
  input  logic [WORDS*32-1:0] app_flat,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             adv,
  output logic [AW-1:0]    adv_next,
  output logic             halt_set,
  output logic             desc_done
);
  localparam int SW = (WORDS > 1) ? $clog2(WORDS) : 1;

  eng_state_t    st;
  logic [AW-1:0] nxt_r, buf_r, byte_addr;
  logic [LW-1:0] len_r, cnt;
  logic          eof_r, pkt_first, sof, accept;
  logic [SW-1:0] app_idx;
  logic [31:0]   sts_word;

  assign rx_ready  = (st == E_DATA) && run_en && !idle && !halted;
  assign accept    = rx_valid && rx_ready;
  assign sof       = pkt_first && (cnt != '0);
  assign byte_addr = buf_r + AW'(cnt);
  assign adv       = (st == E_ADV);
  assign adv_next  = nxt_r;
  assign desc_done = (st == E_ADV);
  assign halt_set  = (st == E_CHK) && mem_rdata[STS_DONE_BIT];

  always_comb begin
    sts_word               = '0;
    sts_word[LW-1:0]       = cnt;
    sts_word[STS_DONE_BIT] = 1'b1;
    sts_word[STS_SOF_BIT]  = sof;
    sts_word[STS_EOF_BIT]  = eof_r;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_be    = 4'b0000;
    mem_wdata = '0;
    case (st)
      E_RD_NXT: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFF_NEXT); end
      E_RD_BUF: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFF_BUF);  end
      E_RD_CTL: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFF_CTL);  end
      E_RD_STS: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(OFF_STS);  end
      E_DATA: begin
        if (accept) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {byte_addr[AW-1:2], 2'b00};
          mem_be    = 4'b0001 << byte_addr[1:0];
          mem_wdata = {4{rx_data}};
        end
      end
      E_WB_STS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'b1111;
        mem_addr  = cur_ptr + AW'(OFF_STS);
        mem_wdata = sts_word;
      end
      E_WB_APP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'b1111;
        mem_addr  = cur_ptr + AW'(OFF_APP) + AW'(4 * int'(app_idx));
        mem_wdata = app_flat[32*int'(app_idx) +: 32];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_WAIT;
      nxt_r     <= '0;
      buf_r     <= '0;
      len_r     <= '0;
      cnt       <= '0;
      eof_r     <= 1'b0;
      pkt_first <= 1'b1;
      app_idx   <= '0;
    end else begin
      case (st)
        E_WAIT:   if (run_en && !idle && !halted) st <= E_RD_NXT;
        E_RD_NXT: st <= E_RD_BUF;
        E_RD_BUF: begin nxt_r <= mem_rdata[AW-1:0]; st <= E_RD_CTL; end
        E_RD_CTL: begin buf_r <= mem_rdata[AW-1:0]; st <= E_RD_STS; end
        E_RD_STS: begin len_r <= mem_rdata[LW-1:0]; st <= E_CHK; end
        E_CHK: begin
          cnt   <= '0;
          eof_r <= 1'b0;
          if (mem_rdata[STS_DONE_BIT]) st <= E_WAIT;
          else if (len_r == '0)        st <= E_WB_STS;
          else                         st <= E_DATA;
        end
        E_DATA: begin
          if (accept) begin
            cnt <= cnt + LW'(1);
            if (rx_last || (cnt + LW'(1)) == len_r) begin
              eof_r <= rx_last;
              st    <= E_WB_STS;
            end
          end
        end
        E_WB_STS: begin
          pkt_first <= eof_r || (pkt_first && cnt == '0);
          app_idx   <= '0;
          st        <= eof_r ? E_WB_APP : E_ADV;
        end
        E_WB_APP: begin
          app_idx <= app_idx + SW'(1);
          if (app_idx == SW'(WORDS - 1)) st <= E_ADV;
        end
        E_ADV:   st <= E_WAIT;
        default: st <= E_WAIT;
      endcase
    end
  end

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    (st == E_DATA) |-> (cnt < len_r)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    desc_done |=> !desc_done); // R10
  AST_APP_ONLY_AT_EOF: assert property (@(posedge clk) disable iff (rst)
    (st == E_WB_APP) |-> eof_r); // R7
  AST_HALT_BLOCKS_DATA: assert property (@(posedge clk) disable iff (rst)
    halt_set |=> !rx_ready); // R3

endmodule

// File: rtl/sg_rx_writer.sv
module sg_rx_writer #(
  parameter int AW       = 32,
  parameter int LW       = 23,
  parameter int SB_WORDS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_wdata,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_wdata,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  input  logic          sb_valid,
  input  logic [31:0]   sb_data,
  input  logic          sb_last,
  output logic          sb_error,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          desc_done
);
  logic [SB_WORDS*32-1:0] app_flat;
  logic                   adv, halt_set;
  logic [AW-1:0]          adv_next;

  sg_rx_sideband #(.WORDS(SB_WORDS), .DW(32)) i_sideband (
    .clk(clk), .rst(rst), .sb_valid(sb_valid), .sb_data(sb_data),
    .sb_last(sb_last), .app_flat(app_flat), .sb_error(sb_error)
  );

  sg_rx_chan_regs #(.AW(AW)) i_regs (
    .clk(clk), .rst(rst), .run_en(run_en),
    .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .tail_wr(tail_wr), .tail_wdata(tail_wdata),
    .adv(adv), .adv_next(adv_next), .halt_set(halt_set),
    .cur_ptr(cur_ptr), .halted(halted), .idle(idle)
  );

  sg_rx_engine #(.AW(AW), .LW(LW), .WORDS(SB_WORDS)) i_engine (
    .clk(clk), .rst(rst), .run_en(run_en), .idle(idle), .halted(halted),
    .cur_ptr(cur_ptr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .app_flat(app_flat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .adv(adv), .adv_next(adv_next), .halt_set(halt_set),
    .desc_done(desc_done)
  );

endmodule

// File: tb/test_sg_rx_writer.sv
`timescale 1ns/1ps
module test_sg_rx_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, cur_wr = 1'b0, tail_wr = 1'b0;
  logic [31:0] cur_wdata = '0, tail_wdata = '0, cur_ptr;
  logic        halted, idle;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        sb_valid = 1'b0, sb_last = 1'b0, sb_error;
  logic [31:0] sb_data = '0;
  logic        mem_req, mem_we, desc_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] ram [0:255];
  logic        tb_wr = 1'b0;
  logic [7:0]  tb_waddr = '0;
  logic [31:0] tb_wdata = '0;
  int          n_chk = 0, n_bad = 0, done_cnt = 0;

  // {packet bytes, descriptor capacity, expected descriptors used}
  localparam logic [23:0] VEC [6] = '{
    {8'd4, 8'd8, 8'd1}, {8'd8, 8'd8, 8'd1}, {8'd9, 8'd4, 8'd3},
    {8'd1, 8'd1, 8'd1}, {8'd7, 8'd3, 8'd3}, {8'd12, 8'd5, 8'd3}
  };

  always #5 clk = ~clk;

  sg_rx_writer i_sg_rx_writer (
    .clk(clk), .rst(rst), .run_en(run_en), .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .tail_wr(tail_wr), .tail_wdata(tail_wdata), .cur_ptr(cur_ptr),
    .halted(halted), .idle(idle), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .sb_valid(sb_valid),
    .sb_data(sb_data), .sb_last(sb_last), .sb_error(sb_error),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .desc_done(desc_done)
  );

  always @(posedge clk) begin
    if (desc_done) done_cnt <= done_cnt + 1;
    if (tb_wr) ram[tb_waddr] <= tb_wdata;
    else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= ram[mem_addr[9:2]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    @(negedge clk); tb_wr = 1'b1; tb_waddr = 8'(a >> 2); tb_wdata = d;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    return 8'(ram[a >> 2] >> (8 * (a % 4)));
  endfunction

  // eight descriptors at 64-byte stride, buffers from 0x200
  task automatic setup_ring(input int cap);
    for (int i = 0; i < 8; i++) begin
      wr_word(64*i + 0, 32'(64 * ((i + 1) % 8)));
      wr_word(64*i + 4, 32'(512 + 64*i));
      wr_word(64*i + 8, 32'(cap));
      for (int w = 3; w < 9; w++) wr_word(64*i + 4*w, 32'h0);
      for (int w = 0; w < 4; w++) wr_word(512 + 64*i + 4*w, 32'h0);
    end
  endtask

  task automatic start_chan(input int tail);
    @(negedge clk); run_en = 1'b0; cur_wr = 1'b1; cur_wdata = 32'h0;
    tail_wr = 1'b1; tail_wdata = 32'(tail);
    @(negedge clk); cur_wr = 1'b0; tail_wr = 1'b0; run_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_sb(input int n, input logic [31:0] base, output logic err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sb_valid = 1'b1; sb_data = base | 32'(i); sb_last = (i == n - 1);
    end
    @(negedge clk); sb_valid = 1'b0; sb_last = 1'b0; err = sb_error;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last);
    rx_valid = 1'b1; rx_data = b; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !idle; i++) @(negedge clk);
  endtask

  initial begin
    logic err;
    int base, p, l, n, cnt_d, a;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {31'b0, halted}, 32'd1, "halted after reset");
    chk("R11", {31'b0, idle}, 32'd0, "idle after reset");
    chk("R11", {31'b0, rx_ready}, 32'd0, "rx_ready after reset");
    chk("R11", {31'b0, desc_done}, 32'd0, "desc_done after reset");
    chk("R11", {31'b0, sb_error}, 32'd0, "sb_error after reset");
    @(negedge clk); rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11", {31'b0, mem_req}, 32'd0, "no memory access while halted");

    // table of packets walked by one loop: R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 6; k++) begin
      p = int'(VEC[k][23:16]); l = int'(VEC[k][15:8]); n = int'(VEC[k][7:0]);
      setup_ring(l);
      start_chan(64 * (n - 1));
      if (k == 0) chk("R11", {31'b0, halted}, 32'd0, "run edge clears halted");
      send_sb(5, 32'hA000_0000 | 32'(k << 8), err);
      base = done_cnt;
      for (int j = 0; j < p; j++) send_byte(8'(k*32 + j), j == p - 1);
      wait_idle();
      @(negedge clk);
      chk("R8", {31'b0, idle}, 32'd1, "idle at tail");
      chk("R8", cur_ptr, 32'(64 * n), "cur_ptr after chain");
      chk("R10", 32'(done_cnt - base), 32'(n), "completion pulses");
      for (int d = 0; d < n; d++) begin
        cnt_d = (d == n - 1) ? p - (n - 1) * l : l;
        chk("R5", ram[(64*d + 12) >> 2],
            32'h8000_0000 | ((d == 0) ? 32'h0800_0000 : 0) |
            ((d == n - 1) ? 32'h0400_0000 : 0) | 32'(cnt_d), "status word (R6 flags)");
      end
      for (int j = 0; j < p; j++) begin
        a = 512 + 64 * (j / l) + (j % l);
        chk("R4", {24'b0, rd_byte(a)}, {24'b0, 8'(k*32 + j)}, "buffer byte");
      end
      for (int i = 0; i < 5; i++)
        chk("R7", ram[(64*(n - 1) + 16 + 4*i) >> 2],
            32'hA000_0000 | 32'(k << 8) | 32'(i), "sideband word");
    end

    // R1: wrong-length sideband groups
    setup_ring(16);
    start_chan(0);
    send_sb(5, 32'hB100_0000, err);
    chk("R1", {31'b0, err}, 32'd0, "five-word group no error");
    send_sb(4, 32'hB200_0000, err);
    chk("R1", {31'b0, err}, 32'd1, "four-word group error");
    send_sb(6, 32'hB300_0000, err);
    chk("R1", {31'b0, err}, 32'd1, "six-word group error");
    send_byte(8'h11, 1'b0); send_byte(8'h22, 1'b1);
    wait_idle(); @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk("R1", ram[(16 + 4*i) >> 2], 32'hB100_0000 | 32'(i), "latched words kept");

    // R2: run level gates rx_ready
    setup_ring(8);
    start_chan(0);
    for (int i = 0; i < 100 && !rx_ready; i++) @(negedge clk);
    chk("R2", {31'b0, rx_ready}, 32'd1, "ready with descriptor loaded");
    run_en = 1'b0; #1;
    chk("R2", {31'b0, rx_ready}, 32'd0, "ready drops with run low");
    @(negedge clk); run_en = 1'b1; @(negedge clk);
    chk("R2", {31'b0, rx_ready}, 32'd1, "ready back with run high");
    send_byte(8'h31, 1'b0); send_byte(8'h32, 1'b0); send_byte(8'h33, 1'b1);
    wait_idle(); @(negedge clk);
    chk("R6", ram[12 >> 2], 32'h8C00_0003, "single descriptor start and end");

    // R3: descriptor already complete
    setup_ring(8);
    wr_word(12, 32'h8000_0000);
    base = done_cnt;
    start_chan(0);
    repeat (20) @(negedge clk);
    chk("R3", {31'b0, halted}, 32'd1, "halted on complete descriptor");
    chk("R3", {31'b0, rx_ready}, 32'd0, "no ready when halted");
    chk("R3", cur_ptr, 32'd0, "cur_ptr unchanged");
    chk("R3", 32'(done_cnt - base), 32'd0, "no write-back");

    // R9: idle in mid-packet, resume on tail write
    setup_ring(4);
    start_chan(0);
    send_sb(5, 32'hC000_0000, err);
    for (int j = 0; j < 4; j++) send_byte(8'(8'h50 + j), 1'b0);
    rx_valid = 1'b1; rx_data = 8'h54; rx_last = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", {31'b0, idle}, 32'd1, "idle mid-packet");
    chk("R9", {31'b0, rx_ready}, 32'd0, "bytes held");
    chk("R9", cur_ptr, 32'd64, "pointer advanced");
    chk("R9", ram[12 >> 2], 32'h8800_0004, "first part status");
    tail_wr = 1'b1; tail_wdata = 32'd64;
    @(negedge clk); tail_wr = 1'b0;
    send_byte(8'h54, 1'b0); send_byte(8'h55, 1'b1);
    wait_idle(); @(negedge clk);
    chk("R9", ram[(64 + 12) >> 2], 32'h8400_0002, "resumed part status no start");
    chk("R9", cur_ptr, 32'd128, "pointer after resume");
    chk("R9", {24'b0, rd_byte(512 + 64 + 1)}, 32'h55, "resumed byte");
    chk("R7", ram[(64 + 16) >> 2], 32'hC000_0000, "sideband in final part");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule